// File: doc/BRIEF.md
# Interprocessor Interrupt Command Dispatcher

This block sits beside one core of an N-core cluster and turns software writes to a two-word interrupt command register into interrupt messages. The high word carries a destination byte. Writing the low word launches the command. The low word holds the vector, delivery mode, destination mode, level, trigger and a destination shorthand. The block works out which cores the command targets. The core's own ID is fixed by a parameter.

A target equal to the own core is served at once through a one-cycle local request. Every other target gets one outgoing message on a valid/ready port. These messages go out one at a time in ascending core order. Each remote message adds one to an outstanding count. A delivery-status bit in the low word reads busy until a completion pulse has arrived for every remote message. While the bit is busy, further launches are refused.

Top module: `ipi_cmd_dispatch`

## Requirements
- R1: After reset both read words are zero, `cmd_busy` is low, and `self_valid`, `msg_valid` and `cmd_error` are low.
- R2: A write to the high word keeps only bits 31:24 (the destination byte). All other bits read back as zero.
- R3: Low-word layout: vector 7:0, delivery mode 10:8, logical destination mode 11, status 12, level 14, trigger 15, shorthand 19:18. Other bits read as zero. Software cannot write the status bit. Bit 12 reads 1 exactly while remote messages are outstanding.
- R4: Shorthand 0 in logical mode (bit 11 = 1) treats the destination byte as a mask. Bit i selects core i, for i below N.
- R5: Shorthand 0 in physical mode behaves as follows:
  - Destination 0xFF targets every core, including the own core.
  - Any other destination below N targets that one core.
  - A destination of N or more, other than 0xFF, targets nothing.
- R6: The nonzero shorthands select targets as follows:
  - Shorthand 1 targets only the own core.
  - Shorthand 2 targets all cores.
  - Shorthand 3 targets all cores except the own core.
- R7: When the own core is a target, `self_valid` pulses for one cycle. The pulse comes in the cycle after the launching write and carries the vector, mode and trigger of the written word. The own core is never sent on the message port and is never counted.
- R8: Each remote target is sent once on the message port, in ascending core-ID order. A message is held stable until `msg_ready` accepts it, and at most one message is sent per cycle. Each message carries the stored vector, mode, destination mode, level and trigger.
- R9: Busy sets in the cycle after a launch that has at least one remote target, and only then. It clears in the cycle after the `msg_done` pulse that brings the outstanding count to zero.
- R10: A low-word write while busy is ignored. The stored fields are unchanged, and no local or remote delivery follows.
- R11: Lowest-priority mode (mode 1) with shorthand 0 is unsupported. Such a launch delivers nothing, leaves busy low and pulses `cmd_error` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel_hi | input | 1 | 1 selects the high word, 0 the low word |
| wr_data | input | 32 | Write data |
| lo_rdata | output | 32 | Low word read value, status at bit 12 |
| hi_rdata | output | 32 | High word read value |
| cmd_busy | output | 1 | Delivery status: remote messages outstanding |
| cmd_error | output | 1 | One-cycle pulse on an unsupported command |
| self_valid | output | 1 | One-cycle local delivery request |
| self_vector | output | 8 | Vector of the local request |
| self_mode | output | 3 | Delivery mode of the local request |
| self_trig | output | 1 | Trigger of the local request |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Outgoing message accepted |
| msg_dest | output | ID_W | Target core of the outgoing message |
| msg_vector | output | 8 | Outgoing vector |
| msg_mode | output | 3 | Outgoing delivery mode |
| msg_logical | output | 1 | Outgoing destination mode |
| msg_level | output | 1 | Outgoing level |
| msg_trig | output | 1 | Outgoing trigger |
| msg_done | input | 1 | One-cycle completion pulse for a remote message |

## Verification
A wrong pending mask shows at the message port within a cycle of the launch, as a missing, repeated or out-of-order destination. A wrong outstanding count shows only later, when busy clears one pulse too early or too late on `msg_done`. A gate that lets a write through while busy shows in the very next cycle, as a changed low word or as a fresh local or remote request. The sweep covers every shorthand, both destination modes and every destination byte up to 15 plus 0xFF. It therefore reaches each target-resolution path, and the drain of each command exposes the count.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int WORD_W      = 32;
    localparam int VEC_W       = 8;
    localparam int DEST_W      = 8;

    // Low-word field positions
    localparam int LO_VEC_LSB   = 0;
    localparam int LO_MODE_LSB  = 8;
    localparam int LO_LOGIC_BIT = 11;
    localparam int LO_STAT_BIT  = 12;
    localparam int LO_LEVEL_BIT = 14;
    localparam int LO_TRIG_BIT  = 15;
    localparam int LO_SH_LSB    = 18;
    localparam int HI_DEST_LSB  = 24;

    localparam logic [WORD_W-1:0] LO_STORE_MASK = 32'h000C_CFFF;
    localparam logic [WORD_W-1:0] HI_STORE_MASK = 32'hFF00_0000;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWPRI = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXT    = 3'd7
    } dmode_e;

    typedef enum logic [1:0] {
        SH_NONE     = 2'd0,
        SH_SELF     = 2'd1,
        SH_ALL_INCL = 2'd2,
        SH_ALL_EXCL = 2'd3
    } shorthand_e;

    typedef struct packed {
        logic [VEC_W-1:0] vector;
        dmode_e           mode;
        logic             logical;
        logic             level;
        logic             trig;
        shorthand_e       sh;
    } ipi_cmd_t;

    function automatic ipi_cmd_t unpack_lo(input logic [WORD_W-1:0] w);
        ipi_cmd_t c;
        c.vector  = w[LO_VEC_LSB +: VEC_W];
        c.mode    = dmode_e'(w[LO_MODE_LSB +: 3]);
        c.logical = w[LO_LOGIC_BIT];
        c.level   = w[LO_LEVEL_BIT];
        c.trig    = w[LO_TRIG_BIT];
        c.sh      = shorthand_e'(w[LO_SH_LSB +: 2]);
        return c;
    endfunction

endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
    import ipi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lo_accept,
    input  logic                 hi_write,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    lo_word,
    output logic [DEST_W-1:0]    dest_byte
);

    logic [WORD_W-1:0] lo_q;
    logic [DEST_W-1:0] dest_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            dest_q <= '0;
        end else begin
            if (lo_accept) begin
                lo_q <= wdata & LO_STORE_MASK;
            end
            if (hi_write) begin
                dest_q <= wdata[HI_DEST_LSB +: DEST_W];
            end
        end
    end

    assign lo_word   = lo_q;
    assign dest_byte = dest_q;

endmodule

// File: rtl/ipi_target_resolve.sv
module ipi_target_resolve
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int SELF_ID   = 1
) (
    input  ipi_cmd_t              cmd,
    input  logic [DEST_W-1:0]     dest,
    output logic [NUM_CORES-1:0]  tgt_mask,
    output logic                  unsupported
);

    localparam logic [NUM_CORES-1:0] ALL_MASK  = {NUM_CORES{1'b1}};
    localparam logic [NUM_CORES-1:0] SELF_MASK = NUM_CORES'(1) << SELF_ID;

    logic [NUM_CORES+DEST_W-1:0] dest_ext;
    logic [NUM_CORES-1:0]        phys_mask;

    assign dest_ext = {{NUM_CORES{1'b0}}, dest};

    always_comb begin
        phys_mask = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            phys_mask[i] = (32'(dest) == 32'(i));
        end
    end

    always_comb begin
        tgt_mask    = '0;
        unsupported = 1'b0;
        unique case (cmd.sh)
            SH_NONE: begin
                if (cmd.mode == DM_LOWPRI) begin
                    unsupported = 1'b1;
                end else if (cmd.logical) begin
                    tgt_mask = dest_ext[NUM_CORES-1:0];
                end else if (dest == 8'hFF) begin
                    tgt_mask = ALL_MASK;
                end else begin
                    tgt_mask = phys_mask;
                end
            end
            SH_SELF:     tgt_mask = SELF_MASK;
            SH_ALL_INCL: tgt_mask = ALL_MASK;
            SH_ALL_EXCL: tgt_mask = ALL_MASK & ~SELF_MASK;
            default:     tgt_mask = '0;
        endcase
    end

endmodule

// File: rtl/ipi_issue_ctrl.sv
module ipi_issue_ctrl #(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = 2,
    parameter int CNT_W     = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [NUM_CORES-1:0]  load_mask,
    input  logic                  ready,
    input  logic                  done,
    output logic                  valid,
    output logic [ID_W-1:0]       dest,
    output logic                  busy
);

    logic [NUM_CORES-1:0] pend_q;
    logic [NUM_CORES-1:0] pick;
    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     load_cnt;

    // Lowest pending core wins
    always_comb begin
        dest = '0;
        pick = '0;
        for (int i = NUM_CORES - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                dest = ID_W'(i);
                pick = NUM_CORES'(1) << i;
            end
        end
    end

    always_comb begin
        load_cnt = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            load_cnt = load_cnt + CNT_W'(load_mask[i]);
        end
    end

    assign valid = |pend_q;
    assign busy  = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (load) begin
                pend_q <= load_mask;
            end else if (valid && ready) begin
                pend_q <= pend_q & ~pick;
            end
            if (load) begin
                cnt_q <= load_cnt;
            end else if (done && busy) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/ipi_cmd_dispatch.sv
module ipi_cmd_dispatch
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int SELF_ID   = 1,
    localparam int ID_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int CNT_W    = $clog2(NUM_CORES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel_hi,
    input  logic [31:0]       wr_data,
    output logic [31:0]       lo_rdata,
    output logic [31:0]       hi_rdata,
    output logic              cmd_busy,
    output logic              cmd_error,
    output logic              self_valid,
    output logic [7:0]        self_vector,
    output logic [2:0]        self_mode,
    output logic              self_trig,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [ID_W-1:0]   msg_dest,
    output logic [7:0]        msg_vector,
    output logic [2:0]        msg_mode,
    output logic              msg_logical,
    output logic              msg_level,
    output logic              msg_trig,
    input  logic              msg_done
);

    localparam logic [NUM_CORES-1:0] SELF_MASK = NUM_CORES'(1) << SELF_ID;

    logic                 lo_accept;
    logic                 hi_write;
    logic [WORD_W-1:0]    lo_word;
    logic [DEST_W-1:0]    dest_byte;
    ipi_cmd_t             new_cmd;
    ipi_cmd_t             held_cmd;
    logic [NUM_CORES-1:0] tgt_mask;
    logic [NUM_CORES-1:0] remote_mask;
    logic                 unsupported;
    logic                 busy;

    logic                 self_q;
    logic                 err_q;
    ipi_cmd_t             self_cmd_q;

    assign lo_accept = wr_en && !wr_sel_hi && !busy;
    assign hi_write  = wr_en && wr_sel_hi;
    assign new_cmd   = unpack_lo(wr_data);
    assign held_cmd  = unpack_lo(lo_word);

    ipi_cmd_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .lo_accept (lo_accept),
        .hi_write  (hi_write),
        .wdata     (wr_data),
        .lo_word   (lo_word),
        .dest_byte (dest_byte)
    );

    ipi_target_resolve #(
        .NUM_CORES (NUM_CORES),
        .SELF_ID   (SELF_ID)
    ) u_resolve (
        .cmd         (new_cmd),
        .dest        (dest_byte),
        .tgt_mask    (tgt_mask),
        .unsupported (unsupported)
    );

    assign remote_mask = tgt_mask & ~SELF_MASK;

    ipi_issue_ctrl #(
        .NUM_CORES (NUM_CORES),
        .ID_W      (ID_W),
        .CNT_W     (CNT_W)
    ) u_issue (
        .clk       (clk),
        .rst       (rst),
        .load      (lo_accept && (remote_mask != '0)),
        .load_mask (remote_mask),
        .ready     (msg_ready),
        .done      (msg_done),
        .valid     (msg_valid),
        .dest      (msg_dest),
        .busy      (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            self_q     <= 1'b0;
            err_q      <= 1'b0;
            self_cmd_q <= '0;
        end else begin
            self_q <= lo_accept && ((tgt_mask & SELF_MASK) != '0);
            err_q  <= lo_accept && unsupported;
            if (lo_accept) begin
                self_cmd_q <= new_cmd;
            end
        end
    end

    assign cmd_busy    = busy;
    assign cmd_error   = err_q;
    assign self_valid  = self_q;
    assign self_vector = self_cmd_q.vector;
    assign self_mode   = self_cmd_q.mode;
    assign self_trig   = self_cmd_q.trig;

    assign msg_vector  = held_cmd.vector;
    assign msg_mode    = held_cmd.mode;
    assign msg_logical = held_cmd.logical;
    assign msg_level   = held_cmd.level;
    assign msg_trig    = held_cmd.trig;

    always_comb begin
        lo_rdata              = lo_word;
        lo_rdata[LO_STAT_BIT] = busy;
    end
    assign hi_rdata = {dest_byte, 24'h0};

endmodule

// File: rtl/ipi_cmd_dispatch_chk.sv
module ipi_cmd_dispatch_chk #(
    parameter int NUM_CORES = 4,
    parameter int SELF_ID   = 1,
    parameter int ID_W      = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic            wr_sel_hi,
    input logic [31:0]     lo_rdata,
    input logic            cmd_busy,
    input logic            cmd_error,
    input logic            self_valid,
    input logic            msg_valid,
    input logic            msg_ready,
    input logic [ID_W-1:0] msg_dest,
    input logic            msg_done
);

    localparam logic [31:0] NO_STAT = ~(32'h1 << 12);

    // R9
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_busy) |-> $past(wr_en && !wr_sel_hi));

    // R9
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_busy) |-> $past(msg_done));

    // R8
    msg_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> cmd_busy);

    // R8
    msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dest)));

    // R8
    msg_order_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready) |=> (!msg_valid || (msg_dest > $past(msg_dest))));

    // R7
    no_self_msg_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (32'(msg_dest) != 32'(SELF_ID)));

    // R7
    self_cause_chk: assert property (@(posedge clk) disable iff (rst)
        self_valid |-> $past(wr_en && !wr_sel_hi && !cmd_busy));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_busy && wr_en && !wr_sel_hi) |=> ((lo_rdata & NO_STAT) == $past(lo_rdata & NO_STAT)));

    // R11
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_error |-> (!self_valid && !$rose(cmd_busy)));

endmodule

bind ipi_cmd_dispatch ipi_cmd_dispatch_chk #(
    .NUM_CORES (NUM_CORES),
    .SELF_ID   (SELF_ID),
    .ID_W      (ID_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel_hi  (wr_sel_hi),
    .lo_rdata   (lo_rdata),
    .cmd_busy   (cmd_busy),
    .cmd_error  (cmd_error),
    .self_valid (self_valid),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_dest   (msg_dest),
    .msg_done   (msg_done)
);

// File: tb/test_ipi_cmd_dispatch.sv
module test_ipi_cmd_dispatch;

    localparam int N    = 4;
    localparam int SELF = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel_hi = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] lo_rdata, hi_rdata;
    logic        cmd_busy, cmd_error, self_valid, self_trig;
    logic [7:0]  self_vector, msg_vector;
    logic [2:0]  self_mode, msg_mode;
    logic        msg_valid, msg_logical, msg_level, msg_trig;
    logic        msg_ready = 1'b0;
    logic        msg_done = 1'b0;
    logic [1:0]  msg_dest;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    ipi_cmd_dispatch i_ipi_cmd_dispatch (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel_hi(wr_sel_hi), .wr_data(wr_data),
        .lo_rdata(lo_rdata), .hi_rdata(hi_rdata), .cmd_busy(cmd_busy), .cmd_error(cmd_error),
        .self_valid(self_valid), .self_vector(self_vector), .self_mode(self_mode),
        .self_trig(self_trig), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_dest(msg_dest), .msg_vector(msg_vector), .msg_mode(msg_mode),
        .msg_logical(msg_logical), .msg_level(msg_level), .msg_trig(msg_trig),
        .msg_done(msg_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] mk_lo(input logic [7:0] vec, input logic [2:0] mode,
                                          input bit logical, input bit lvl, input bit trig,
                                          input logic [1:0] sh);
        return 32'(vec) | (32'(mode) << 8) | (32'(logical) << 11) | (32'(lvl) << 14)
             | (32'(trig) << 15) | (32'(sh) << 18);
    endfunction

    function automatic logic [3:0] exp_tgt(input logic [1:0] sh, input bit logical,
                                           input logic [7:0] d, input logic [2:0] mode);
        case (sh)
            2'd0: begin
                if (mode == 3'd1) return 4'b0000;
                if (logical) return d[3:0];
                if (d == 8'hFF) return 4'b1111;
                if (d < 8'd4) return 4'b0001 << d;
                return 4'b0000;
            end
            2'd1: return 4'b0010;
            2'd2: return 4'b1111;
            default: return 4'b1101;
        endcase
    endfunction

    task automatic wr(input bit hi, input logic [31:0] d);
        wr_en = 1'b1; wr_sel_hi = hi; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel_hi = 1'b0; wr_data = '0;
    endtask

    // Launch one command, optionally try a write while busy, then drain it.
    task automatic run_cmd(input int idx, input logic [7:0] dest, input logic [7:0] vec,
                           input logic [2:0] mode, input bit logical, input logic [1:0] sh,
                           input bit intrude);
        logic [3:0]  tgt, remote, got;
        logic [31:0] lo;
        int          n, last;
        bit          order_ok, field_ok, err_exp;
        tgt    = exp_tgt(sh, logical, dest, mode);
        remote = tgt & 4'b1101;
        n      = $countones(remote);
        lo     = mk_lo(vec, mode, logical, idx[0], idx[1], sh);
        err_exp = (sh == 2'd0) && (mode == 3'd1);
        wr(1'b1, {dest, 24'h0});
        wr(1'b0, lo);
        // R7 local delivery one cycle after the launch
        chk(self_valid == tgt[SELF], "R7 self_valid", 32'(self_valid), 32'(tgt[SELF]));
        if (tgt[SELF])
            chk(self_vector == vec && self_mode == mode, "R7 self fields",
                {self_mode, self_vector}, {mode, vec});
        // R9 busy only with remote targets
        chk(cmd_busy == (remote != 0), "R9 busy set", 32'(cmd_busy), 32'(remote != 0));
        // R11
        chk(cmd_error == err_exp, "R11 error pulse", 32'(cmd_error), 32'(err_exp));
        // R3 readback with status bit
        chk(lo_rdata == ((lo & 32'h000CCFFF) | (32'(remote != 0) << 12)), "R3 low readback",
            lo_rdata, (lo & 32'h000CCFFF) | (32'(remote != 0) << 12));
        if (intrude && remote != 0) begin
            wr(1'b0, mk_lo(8'hA5, 3'd0, 1'b0, 1'b0, 1'b0, 2'd1));
            // R10 ignored write: no local pulse, fields kept
            chk(!self_valid, "R10 no self", 32'(self_valid), 0);
            chk(lo_rdata == ((lo & 32'h000CCFFF) | 32'h1000), "R10 low kept",
                lo_rdata, (lo & 32'h000CCFFF) | 32'h1000);
        end
        got = '0; last = -1; order_ok = 1'b1; field_ok = 1'b1;
        for (int it = 0; it < 14; it++) begin
            msg_ready = ((it + idx) % 3) != 0;
            #1;
            if (msg_valid && msg_ready) begin
                if (int'(msg_dest) <= last || got[msg_dest] || msg_dest == 2'(SELF)) order_ok = 1'b0;
                if (msg_vector != vec || msg_mode != mode || msg_logical != logical) field_ok = 1'b0;
                last = int'(msg_dest);
                got[msg_dest] = 1'b1;
            end
            @(negedge clk);
        end
        msg_ready = 1'b0;
        // R8 all remote targets, ascending, once each
        chk(got == remote && order_ok, "R8 message set", 32'(got), 32'(remote));
        chk(field_ok, "R8 message fields", 32'(field_ok), 1);
        // R4 R5 R6 target sets (local plus remote)
        chk({got[3:2], self_valid | tgt[SELF], got[0]} == tgt,
            (sh == 0) ? (logical ? "R4 logical targets" : "R5 physical targets") : "R6 shorthand targets",
            32'(got), 32'(tgt));
        for (int k = 0; k < n; k++) begin
            chk(cmd_busy, "R9 busy held", 32'(cmd_busy), 1);
            msg_done = 1'b1;
            @(negedge clk);
            msg_done = 1'b0;
        end
        chk(!cmd_busy && lo_rdata[12] == 1'b0, "R9 busy cleared", 32'(cmd_busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        chk(lo_rdata == 0 && hi_rdata == 0, "R1 reset words", lo_rdata | hi_rdata, 0);
        chk(!cmd_busy && !msg_valid && !self_valid && !cmd_error, "R1 reset flags",
            {cmd_busy, msg_valid, self_valid, cmd_error}, 0);
        // R2
        wr(1'b1, 32'hFFFF_FFFF);
        chk(hi_rdata == 32'hFF00_0000, "R2 high mask", hi_rdata, 32'hFF00_0000);
        // R3 status bit not writable
        wr(1'b1, 32'h0);
        wr(1'b0, mk_lo(8'h21, 3'd0, 1'b0, 1'b1, 1'b1, 2'd1) | 32'hFFF3_3000);
        chk(lo_rdata == (mk_lo(8'h21, 3'd0, 1'b0, 1'b1, 1'b1, 2'd1)), "R3 status read-only",
            lo_rdata, mk_lo(8'h21, 3'd0, 1'b0, 1'b1, 1'b1, 2'd1));
        @(negedge clk);
        // Sweep shorthand 0, both modes, destinations 0..15 and 0xFF
        for (int lg = 0; lg < 2; lg++) begin
            for (int d = 0; d < 17; d++) begin
                run_cmd(d + lg * 17, (d == 16) ? 8'hFF : 8'(d), 8'(8'h40 + d), 3'd0,
                        lg[0], 2'd0, 1'b0);
            end
        end
        // Shorthands 1..3 with several modes
        for (int sh = 1; sh < 4; sh++) begin
            run_cmd(40 + sh, 8'h02, 8'(8'h80 + sh), 3'd4, 1'b0, 2'(sh), 1'b0);
            run_cmd(50 + sh, 8'hFF, 8'(8'h90 + sh), 3'd1, 1'b1, 2'(sh), 1'b0);
        end
        // R11 lowest priority with shorthand 0, both modes
        run_cmd(60, 8'hFF, 8'h55, 3'd1, 1'b0, 2'd0, 1'b0);
        run_cmd(61, 8'h0F, 8'h56, 3'd1, 1'b1, 2'd0, 1'b0);
        // R10 write while busy
        run_cmd(62, 8'h00, 8'h33, 3'd0, 1'b0, 2'd3, 1'b1);
        run_cmd(63, 8'hFF, 8'h34, 3'd5, 1'b0, 2'd0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule